// File: doc/BRIEF.md
# Receiver Input Select and Format Stage

This block is the first stage of a digital downconverter channel. It takes one 16-bit sample source per clock and passes one two's-complement word toward the mixer, together with a valid flag. The source is either one of four external sample buses, each with its own active-low enable pin, or a test word loaded by a processor write. A single internal 16-bit control register, written through `cfg_wr`/`cfg_din`, sets the source, the enable source, the flow mode, the channel delay and the number format.

Two flow modes exist. Gated mode moves one sample per asserted enable and stalls otherwise. Interpolated mode runs every clock and inserts zeros where the enable is low. For time-multiplexed input, a one-clock marker on the first channel's word is delayed by a programmed 0 to 7 clocks to capture one channel. The captured word is then realigned to the next marker. Offset-binary input is handled by flipping the MSB. Four packed floating-point layouts are expanded to fixed point. After reset all enables are held off until the first `sync_in` pulse.

Top module: `rx_input_stage`

## Requirements
- R1: Control bits 14:13 choose bus A (0), B (1), C (2) or D (3) when bit 15 is 0. Only the chosen bus's data and enable pin reach the output, and an enable pin counts as asserted when it is low (`bus_en_n[k]` = 0).
- R2: With bit 15 set, the test word is the source. Bit 12 = 0 takes the enable from bit 11. Bit 12 = 1 makes each `test_wr` write produce exactly one enable for the word just written, and the bus enable pins are then ignored.
- R3: Reset clears the control register to 0, which selects bus A, gated mode, fixed point, two's complement and delay 0. Reset also drives `out_valid` and `out_data` to 0. No valid output appears until a `sync_in` pulse has been seen, even while enables are asserted.
- R4: In gated mode (bit 3 = 0), `out_valid` pulses once per accepted enable and `out_data` changes only on those pulses. Each pulse carries the word captured at the previous enable.
- R5: In interpolated mode (bit 3 = 1), `out_valid` is high on every clock once released. `out_data` is exactly 0 on clocks that carry no enable.
- R6: With delay N in bits 6:4, and an enable marking channel 0 of each frame of consecutive words, the word presented N clocks after a marker is captured. That word appears at the output on the next frame's marker, provided frames are at least N+1 clocks long.
- R7: Bit 10 = 1 treats the input as offset binary and inverts its MSB before any other conversion.
- R8: Bit 9 = 1 decodes a float with the signed mantissa in the top bits and the exponent in the low bits. Bits 8:7 choose mantissa/exponent widths 00 = 11/3, 01 = 12/3, 10 = 13/3, 11 = 14/2. The result is the mantissa left-justified in 16 bits and shifted arithmetically right by (maximum exponent − exponent).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads `cfg_din` into the control register |
| cfg_din | input | 16 | Control register write data |
| bus_a | input | 16 | External sample bus A |
| bus_b | input | 16 | External sample bus B |
| bus_c | input | 16 | External sample bus C |
| bus_d | input | 16 | External sample bus D |
| bus_en_n | input | 4 | Active-low enables, bit k for bus k (A = 0) |
| test_wr | input | 1 | Loads `test_din` into the test word register |
| test_din | input | 16 | Test word write data |
| sync_in | input | 1 | Releases the enable hold-off on its first pulse |
| out_data | output | 16 | Two's-complement sample toward the mixer |
| out_valid | output | 1 | Sample valid / processing enable |

## Verification
A fault in the release flag shows up as valid pulses before any sync, or as a stream that never starts, within three clocks of the enable. A fault in the enable delay line or the capture register surfaces at the next frame marker as a word from the wrong channel or from the wrong frame. Any of the five wrongly decoded format fields shows up as a wrong word about five clocks after the sample enters. A gated or interpolated flow error alters the count of valid pulses or zeros within a single enable period.

// File: rtl/ris_pkg.sv
package ris_pkg;

  localparam int WORD_W = 16;

  typedef struct packed {
    logic       ext_test;    // 15
    logic [1:0] bus_sel;     // 14:13
    logic       tst_en_src;  // 12: 1 = write strobe, 0 = register bit
    logic       tst_en_bit;  // 11
    logic       offs_bin;    // 10
    logic       is_float;    // 9
    logic [1:0] flt_fmt;     // 8:7
    logic [2:0] ch_dly;      // 6:4
    logic       interp;      // 3
    logic [2:0] spare;       // 2:0
  } ris_cfg_t;

  // mantissa left-justified, arithmetic right shift by (max exp - exp)
  function automatic logic [WORD_W-1:0] flt2fix(input logic [WORD_W-1:0] w,
                                                input logic [1:0] fmt);
    logic [WORD_W-1:0] m;
    logic [3:0]        sh;
    case (fmt)
      2'd0:    begin m = {w[15:5], 5'b0}; sh = {1'b0, 3'd7 - w[2:0]}; end
      2'd1:    begin m = {w[15:4], 4'b0}; sh = {1'b0, 3'd7 - w[2:0]}; end
      2'd2:    begin m = {w[15:3], 3'b0}; sh = {1'b0, 3'd7 - w[2:0]}; end
      default: begin m = {w[15:2], 2'b0}; sh = {2'b0, 2'd3 - w[1:0]}; end
    endcase
    return $signed(m) >>> sh;
  endfunction

endpackage

// File: rtl/ris_src_sel.sv
module ris_src_sel
  import ris_pkg::*;
#(
  parameter int NBUS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ris_cfg_t                    cfg,
  input  logic [NBUS-1:0][WORD_W-1:0] bus_data,
  input  logic [NBUS-1:0]             bus_en_n,
  input  logic                        test_wr,
  input  logic [WORD_W-1:0]           test_din,
  input  logic                        sync_in,
  output logic [WORD_W-1:0]           s_data,
  output logic                        s_en,
  output logic                        s_rel
);

  logic [WORD_W-1:0] test_q;
  logic              stb_q;
  logic              rel_q;
  logic [WORD_W-1:0] sel_data;
  logic              sel_en;

  always_comb begin
    if (cfg.ext_test) begin
      sel_data = test_q;
      sel_en   = cfg.tst_en_src ? stb_q : cfg.tst_en_bit;
    end else begin
      sel_data = bus_data[cfg.bus_sel];
      sel_en   = ~bus_en_n[cfg.bus_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      test_q <= '0;
      stb_q  <= 1'b0;
      rel_q  <= 1'b0;
      s_data <= '0;
      s_en   <= 1'b0;
      s_rel  <= 1'b0;
    end else begin
      if (test_wr) test_q <= test_din;
      stb_q  <= test_wr;
      rel_q  <= rel_q | sync_in;
      s_data <= sel_data;
      s_en   <= sel_en & rel_q;
      s_rel  <= rel_q;
    end
  end

  // R2: in strobe mode an enable exists only two clocks after a test write
  assert_strobe_from_write_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg.ext_test & cfg.tst_en_src) && s_en) |-> $past(test_wr, 2));

endmodule

// File: rtl/ris_fmt.sv
module ris_fmt
  import ris_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ris_cfg_t          cfg,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_en,
  input  logic              s_rel,
  output logic [WORD_W-1:0] f_data,
  output logic              f_en,
  output logic              f_rel
);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] conv;

  always_comb begin
    word = {s_data[WORD_W-1] ^ cfg.offs_bin, s_data[WORD_W-2:0]};
    conv = cfg.is_float ? flt2fix(word, cfg.flt_fmt) : word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_data <= '0;
      f_en   <= 1'b0;
      f_rel  <= 1'b0;
    end else begin
      f_data <= conv;
      f_en   <= s_en;
      f_rel  <= s_rel;
    end
  end

  // R8: float expansion keeps the sign of the (MSB-corrected) mantissa
  assert_float_sign_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cfg.is_float) |-> (f_data[WORD_W-1] == $past(s_data[WORD_W-1] ^ cfg.offs_bin)));

endmodule

// File: rtl/ris_demux.sv
module ris_demux
  import ris_pkg::*;
#(
  parameter int MAX_CH = 8,
  localparam int DLY_W = $clog2(MAX_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              interp,
  input  logic [DLY_W-1:0]  dly,
  input  logic [WORD_W-1:0] f_data,
  input  logic              f_en,
  input  logic              f_rel,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid
);

  logic [MAX_CH-1:1] en_pipe;   // en_pipe[k] = f_en delayed k clocks
  logic [MAX_CH-1:0] en_all;
  logic              tap;
  logic [WORD_W-1:0] cap;

  always_comb begin
    en_all = {en_pipe, f_en};
    tap    = en_all[dly];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_pipe   <= '0;
      cap       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      en_pipe <= {en_pipe[MAX_CH-2:1], f_en};
      if (tap) cap <= f_data;
      if (interp) begin
        out_valid <= f_rel;
        out_data  <= f_en ? cap : '0;
      end else begin
        out_valid <= f_en;
        if (f_en) out_data <= cap;
      end
    end
  end

  // R4: in gated mode the output word moves only on an accepted enable
  assert_gated_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!interp && !$past(interp) && !$stable(out_data)) |-> $past(f_en));

endmodule

// File: rtl/rx_input_stage.sv
module rx_input_stage
  import ris_pkg::*;
#(
  parameter int NBUS   = 4,
  parameter int MAX_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_din,
  input  logic [15:0]       bus_a,
  input  logic [15:0]       bus_b,
  input  logic [15:0]       bus_c,
  input  logic [15:0]       bus_d,
  input  logic [3:0]        bus_en_n,
  input  logic              test_wr,
  input  logic [15:0]       test_din,
  input  logic              sync_in,
  output logic [15:0]       out_data,
  output logic              out_valid
);

  localparam int DLY_W = $clog2(MAX_CH);

  ris_cfg_t                    cfg_q;
  logic [NBUS-1:0][WORD_W-1:0] bus_arr;
  logic [WORD_W-1:0]           s_data, f_data;
  logic                        s_en, s_rel, f_en, f_rel;

  always_comb bus_arr = {bus_d, bus_c, bus_b, bus_a};

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_wr) cfg_q <= ris_cfg_t'(cfg_din);
  end

  ris_src_sel #(.NBUS(NBUS)) u_src (
    .clk(clk), .rst(rst), .cfg(cfg_q), .bus_data(bus_arr), .bus_en_n(bus_en_n),
    .test_wr(test_wr), .test_din(test_din), .sync_in(sync_in),
    .s_data(s_data), .s_en(s_en), .s_rel(s_rel)
  );

  ris_fmt u_fmt (
    .clk(clk), .rst(rst), .cfg(cfg_q), .s_data(s_data), .s_en(s_en), .s_rel(s_rel),
    .f_data(f_data), .f_en(f_en), .f_rel(f_rel)
  );

  ris_demux #(.MAX_CH(MAX_CH)) u_dmx (
    .clk(clk), .rst(rst), .interp(cfg_q.interp), .dly(DLY_W'(cfg_q.ch_dly)),
    .f_data(f_data), .f_en(f_en), .f_rel(f_rel),
    .out_data(out_data), .out_valid(out_valid)
  );

  // checker state: release seen and steady interpolated run
  logic       sync_seen;
  logic [2:0] rel_cnt;
  logic [2:0] int_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_seen <= 1'b0;
      rel_cnt   <= '0;
      int_cnt   <= '0;
    end else begin
      if (sync_in) sync_seen <= 1'b1;
      if (sync_seen && rel_cnt != 3'd7) rel_cnt <= rel_cnt + 3'd1;
      if (!cfg_q.interp)         int_cnt <= '0;
      else if (int_cnt != 3'd7)  int_cnt <= int_cnt + 3'd1;
    end
  end

  assert_holdoff_R3: assert property (@(posedge clk) disable iff (rst)
    !sync_seen |-> !out_valid);

  assert_interp_every_clock_R5: assert property (@(posedge clk) disable iff (rst)
    (rel_cnt >= 3'd4 && int_cnt >= 3'd2) |-> out_valid);

endmodule

// File: tb/tb_rx_input_stage.sv
`timescale 1ns/1ps
module tb_rx_input_stage;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_din = '0;
  logic [15:0] bus_a = '0, bus_b = '0, bus_c = '0, bus_d = '0;
  logic [3:0]  bus_en_n = 4'hF;
  logic        test_wr = 1'b0;
  logic [15:0] test_din = '0;
  logic        sync_in = 1'b0;
  logic [15:0] out_data;
  logic        out_valid;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rx_input_stage dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_din(cfg_din),
    .bus_a(bus_a), .bus_b(bus_b), .bus_c(bus_c), .bus_d(bus_d),
    .bus_en_n(bus_en_n), .test_wr(test_wr), .test_din(test_din),
    .sync_in(sync_in), .out_data(out_data), .out_valid(out_valid)
  );

  // {cfg, input word, expected output}: bus A, gated, delay 0, steady enable
  localparam logic [47:0] VEC [13] = '{
    {16'h0000, 16'h1234, 16'h1234},   // R7 two's complement passthrough
    {16'h0400, 16'h8000, 16'h0000},   // R7 offset binary
    {16'h0400, 16'h0001, 16'h8001},   // R7
    {16'h0200, 16'h8000, 16'hFF00},   // R8 11/3 exp 0
    {16'h0200, 16'h0027, 16'h0020},   // R8 11/3 exp 7
    {16'h0200, 16'h0025, 16'h0008},   // R8 11/3 exp 5
    {16'h0280, 16'h7FF3, 16'h07FF},   // R8 12/3 exp 3
    {16'h0280, 16'h7FF7, 16'h7FF0},   // R8 12/3 exp 7
    {16'h0300, 16'hFFF9, 16'hFFFF},   // R8 13/3 exp 1
    {16'h0300, 16'h4006, 16'h2000},   // R8 13/3 exp 6
    {16'h0380, 16'h4001, 16'h1000},   // R8 14/2 exp 1
    {16'h0380, 16'hC003, 16'hC000},   // R8 14/2 exp 3
    {16'h0780, 16'h4003, 16'hC000}    // R7 + R8 offset binary float
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    cfg_din = v; cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  task automatic write_test(input logic [15:0] v);
    test_din = v; test_wr = 1'b1;
    tick(1);
    test_wr = 1'b0;
  endtask

  initial begin
    int cnt, nz, bad;
    logic [15:0] last;
    logic [15:0] outs [8];

    // R3: reset state
    tick(3);
    chk("R3 reset valid", {15'b0, out_valid}, 16'h0);
    chk("R3 reset data", out_data, 16'h0);
    rst = 1'b0;

    // R3: hold-off with enable asserted and no sync
    bus_a = 16'h5555; bus_en_n = 4'b1110;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin tick(1); if (out_valid) cnt++; end
    chk("R3 holdoff valid count", 16'(cnt), 16'h0);
    sync_in = 1'b1; tick(1); sync_in = 1'b0;
    tick(5);
    chk("R3 released valid", {15'b0, out_valid}, 16'h1);
    chk("R1 reset selects bus A", out_data, 16'h5555);

    // R7 / R8: vector table
    foreach (VEC[k]) begin
      write_cfg(VEC[k][47:32]);
      bus_a = VEC[k][31:16];
      tick(6);
      chk($sformatf("R8/R7 vector %0d data", k), out_data, VEC[k][15:0]);
      chk($sformatf("R4 vector %0d valid", k), {15'b0, out_valid}, 16'h1);
    end

    // R1: bus C selected, enable of A ignored
    write_cfg(16'h4000);
    bus_a = 16'h1111; bus_c = 16'h3333; bus_en_n = 4'b1110;
    tick(6);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin tick(1); if (out_valid) cnt++; end
    chk("R1 unselected enable ignored", 16'(cnt), 16'h0);
    bus_en_n = 4'b1010;
    tick(6);
    chk("R1 bus C data", out_data, 16'h3333);
    chk("R1 bus C valid", {15'b0, out_valid}, 16'h1);

    // R4: gated, one pulse per enable, word of the previous enable
    write_cfg(16'h0000);
    bus_en_n = 4'hF;
    tick(6);
    cnt = 0; last = '0;
    for (int i = 0; i < 34; i++) begin
      if (i < 24 && i % 3 == 0) begin bus_en_n = 4'b1110; bus_a = 16'h0A00 + 16'(i / 3); end
      else bus_en_n = 4'hF;
      tick(1);
      if (out_valid) begin cnt++; last = out_data; end
    end
    chk("R4 gated pulse count", 16'(cnt), 16'd8);
    chk("R4 gated last word", last, 16'h0A06);

    // R2: test word with register-bit enable
    write_test(16'hABCD);
    write_cfg(16'h8800);
    tick(6);
    chk("R2 bit enable data", out_data, 16'hABCD);
    chk("R2 bit enable valid", {15'b0, out_valid}, 16'h1);

    // R2: strobe enable, bus enables ignored
    write_cfg(16'h9000);
    bus_en_n = 4'b0000;
    tick(6);
    cnt = 0; last = '0;
    for (int i = 0; i < 20; i++) begin
      test_wr  = (i == 2 || i == 8);
      test_din = (i == 2) ? 16'h0F0F : 16'h7070;
      tick(1);
      if (out_valid) begin cnt++; last = out_data; end
    end
    test_wr = 1'b0;
    chk("R2 strobe pulse count", 16'(cnt), 16'd2);
    chk("R2 strobe word", last, 16'h0F0F);

    // R5: interpolated zero stuffing, enable every 4th clock
    write_cfg(16'h0008);
    bus_a = 16'h0042;
    cnt = 0; nz = 0; bad = 0;
    for (int i = 0; i < 24; i++) begin
      bus_en_n = (i % 4 == 0) ? 4'b1110 : 4'hF;
      tick(1);
      if (i >= 8) begin
        if (out_valid) cnt++;
        if (out_data != 16'h0) begin nz++; if (out_data != 16'h0042) bad++; end
      end
    end
    chk("R5 valid every clock", 16'(cnt), 16'd16);
    chk("R5 nonzero count", 16'(nz), 16'd4);
    chk("R5 nonzero value", 16'(bad), 16'd0);

    // R6: channel demux, delays 0 and 7
    for (int n = 0; n < 8; n += 7) begin
      write_cfg(16'(n << 4));
      bus_en_n = 4'hF;
      tick(6);
      cnt = 0;
      for (int i = 0; i < 52; i++) begin
        if (i < 48) begin
          bus_a    = 16'h1000 + 16'((i / 8) * 16 + i % 8);
          bus_en_n = (i % 8 == 0) ? 4'b1110 : 4'hF;
        end else bus_en_n = 4'hF;
        tick(1);
        if (out_valid) begin
          if (cnt < 8) outs[cnt] = out_data;
          cnt++;
        end
      end
      chk($sformatf("R6 delay %0d output count", n), 16'(cnt), 16'd6);
      for (int j = 1; j < 6; j++)
        chk($sformatf("R6 delay %0d frame %0d", n, j - 1), outs[j],
            16'h1000 + 16'((j - 1) * 16 + n));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2000000;
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule